// File: doc/BRIEF.md
# Dual-Input Capture Timer Channel

This block is a single timer channel that measures the timing of two external signals. An 8-bit prescaler divides the clock and advances a 16-bit up-counter. Each of two input pins is watched for a programmable transition. When that transition arrives, the current counter value is copied into the capture register that belongs to that pin. The first pin feeds the period capture register and the second pin feeds the duty capture register. A capture may also restart the counter from zero, which lets the channel measure intervals between edges directly.

Three hardware events set pending flags: a capture on either pin and a counter wrap. Each pending flag has an enable bit, and a single request line reports any enabled pending flag. Software clears a flag by writing 1 to its bit. A low-power control stops the prescaler and counter and holds their contents. In low power, writes to the counter and capture registers are ignored and flags cannot be cleared. A debug freeze input halts counting and masks captures for as long as it is high. Every register can be read at any time through a simple single-cycle register port.

Top module: `capture_timer_chan`

## Requirements
- R1: After reset, every register reads 0 and irq_o is low.
- R2: The counter (address 2) counts only when the mode field CTRL[1:0] is 11 and the run bit CTRL[2] is 1. It advances once every P+1 enabled clock edges, where P is PRESC[7:0] (address 1). A write to PRESC restarts the division phase.
- R3: When the counter wraps from 16'hFFFF to 0 it sets pending bit 2 (bit C) in PEND (address 6).
- R4: Edge select for the first pin is CTRL[5:4] and for the second pin is CTRL[7:6]. The encoding is 00 none, 01 rising, 10 falling, 11 both. Each pin passes through a two-flop synchronizer. A change that arrives before edge N loads its capture register at edge N+2, with the counter value that was present before that edge. Captures work only when CTRL[1:0] is 11, whether or not the run bit is set.
- R5: A capture on the first pin loads CAP_A (address 3) and sets pending bit 0. A capture on the second pin loads CAP_B (address 4) and sets pending bit 1.
- R6: Restart bits CTRL[8] (first pin) and CTRL[9] (second pin) clear the counter to 0 on the same edge that latches the capture.
- R7: irq_o is high exactly when some bit of PEND & EN is set, where EN is address 5 with bits [3:0]. Writing 1 to a PEND bit clears it, and writing 0 leaves it unchanged.
- R8: A hardware set of a pending bit in the same cycle as a software clear of that bit leaves the bit set.
- R9: While the low-power bit CTRL[3] is 1, the counter and prescaler hold their values. In this state, writes to COUNT, CAP_A and CAP_B are ignored, pending bits cannot be cleared, and pin edges cause no capture.
- R10: While freeze_i is high, the counter holds and pin edges cause no capture. When freeze_i falls, counting resumes from the held value.
- R11: All registers read back at any time, including during low power and freeze. Pending bit 3 (bit D) is never set, and addresses 7 and above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| freeze_i | input | 1 | Debug freeze: halts counting and masks captures |
| cap_a_i | input | 1 | First capture pin (period) |
| cap_b_i | input | 1 | Second capture pin (duty) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong prescaler phase or counter gating appears in COUNT within one prescale period of enabling. It shows as a count that differs from the number of enabled edges divided by P+1. A wrong synchronizer depth or edge decode shows at the next pin transition, either as a capture value off by one count or as a missing capture. A wrong pending update shows on irq_o in the cycle after the event. This matters most for the set-versus-clear collision and for clears attempted in low power, where the flag must survive and the request must stay high.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_IRQ  = 4;
  localparam int unsigned N_PIN  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRESC = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAPA  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAPB  = 3'd4;
  localparam logic [ADDR_W-1:0] A_EN    = 3'd5;
  localparam logic [ADDR_W-1:0] A_PEND  = 3'd6;

  localparam logic [1:0] MODE_CAPTURE = 2'b11;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic [1:0] restart;
    logic [1:0] edge_b;
    logic [1:0] edge_a;
    logic       lowpwr;
    logic       run;
    logic [1:0] mode;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ctc_edge_det.sv
module ctc_edge_det
  import ctc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sig_i,
  input  edge_sel_e sel_i,
  output logic      evt_o
);
  logic sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= sig_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  logic rise, fall;
  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: evt_o = rise;
      EDGE_FALL: evt_o = fall;
      EDGE_BOTH: evt_o = rise | fall;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
  parameter int unsigned PS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] div_i,
  output logic            tick_o
);
  logic [PS_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ctc_irq.sv
module ctc_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  input  logic         clr_block_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q, en_q, clr;

  assign clr = (clr_we_i && !clr_block_i) ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | set_i;  // set wins
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = |(pend_q & en_q);
endmodule

// File: rtl/capture_timer_chan.sv
module capture_timer_chan
  import ctc_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freeze_i,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  ctrl_t            ctrl_q;
  logic [PS_W-1:0]  presc_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cap_q [N_PIN];
  logic [N_IRQ-1:0] pend, en;

  logic is_cap_mode, count_en, cap_ok, tick;
  logic wr_ctrl, wr_presc, wr_count, wr_en_reg, wr_pend;
  logic [N_PIN-1:0] raw_evt, evt, wr_cap;
  logic restart;
  logic ovf;

  assign is_cap_mode = (ctrl_q.mode == MODE_CAPTURE);
  assign count_en    = is_cap_mode && ctrl_q.run && !ctrl_q.lowpwr && !freeze_i;
  assign cap_ok      = is_cap_mode && !ctrl_q.lowpwr && !freeze_i;

  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_presc  = wr_en_i && (addr_i == A_PRESC);
  assign wr_count  = wr_en_i && (addr_i == A_COUNT) && !ctrl_q.lowpwr;
  assign wr_en_reg = wr_en_i && (addr_i == A_EN);
  assign wr_pend   = wr_en_i && (addr_i == A_PEND);
  assign wr_cap[0] = wr_en_i && (addr_i == A_CAPA) && !ctrl_q.lowpwr;
  assign wr_cap[1] = wr_en_i && (addr_i == A_CAPB) && !ctrl_q.lowpwr;

  // pin front ends
  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    logic      pin;
    edge_sel_e sel;
    if (g == 0) begin : g_a
      assign pin = cap_a_i;
      assign sel = edge_sel_e'(ctrl_q.edge_a);
    end else begin : g_b
      assign pin = cap_b_i;
      assign sel = edge_sel_e'(ctrl_q.edge_b);
    end

    ctc_edge_det u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (pin),
      .sel_i  (sel),
      .evt_o  (raw_evt[g])
    );

    assign evt[g] = raw_evt[g] && cap_ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cap_q[g] <= '0;
      else if (evt[g])    cap_q[g] <= count_q;
      else if (wr_cap[g]) cap_q[g] <= wdata_i;
    end
  end

  assign restart = |(evt & ctrl_q.restart);

  ctc_prescaler #(.PS_W(PS_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (count_en),
    .clr_i  (wr_presc && !ctrl_q.lowpwr),
    .div_i  (presc_q),
    .tick_o (tick)
  );

  assign ovf = tick && (count_q == CNT_MAX) && !wr_count && !restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      count_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_presc) presc_q <= wdata_i[PS_W-1:0];
      if (wr_count)     count_q <= wdata_i;
      else if (restart) count_q <= '0;
      else if (tick)    count_q <= count_q + 1'b1;
    end
  end

  ctc_irq #(.N(N_IRQ)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       ({1'b0, ovf, evt[1], evt[0]}),
    .clr_we_i    (wr_pend),
    .clr_mask_i  (wdata_i[N_IRQ-1:0]),
    .clr_block_i (ctrl_q.lowpwr),
    .en_we_i     (wr_en_reg),
    .en_wdata_i  (wdata_i[N_IRQ-1:0]),
    .pend_o      (pend),
    .en_o        (en),
    .irq_o       (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
      A_PRESC: rdata_o[PS_W-1:0]   = presc_q;
      A_COUNT: rdata_o             = count_q;
      A_CAPA:  rdata_o             = cap_q[0];
      A_CAPB:  rdata_o             = cap_q[1];
      A_EN:    rdata_o[N_IRQ-1:0]  = en;
      A_PEND:  rdata_o[N_IRQ-1:0]  = pend;
      default: rdata_o             = '0;
    endcase
  end
endmodule

// File: rtl/capture_timer_chan_chk.sv
module capture_timer_chan_chk
  import ctc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              freeze_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  cap_a,
  input logic [CNT_W-1:0]  cap_b,
  input logic              lowpwr,
  input logic [N_IRQ-1:0]  pend
);
  logic wr_cnt, wr_caps;
  assign wr_cnt  = wr_en_i && (addr_i == A_COUNT);
  assign wr_caps = wr_en_i && ((addr_i == A_CAPA) || (addr_i == A_CAPB));

  p_lowpwr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr |=> $stable(count_q));

  p_lowpwr_noclr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr |=> (($past(pend) & ~pend) == '0));

  p_freeze_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !wr_cnt) |=> $stable(count_q));

  p_freeze_nocap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !wr_caps) |=> ($stable(cap_a) && $stable(cap_b)));

  p_bit_d_unused_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend[3]);
endmodule

bind capture_timer_chan capture_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .freeze_i (freeze_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .count_q  (count_q),
  .cap_a    (cap_q[0]),
  .cap_b    (cap_q[1]),
  .lowpwr   (ctrl_q.lowpwr),
  .pend     (pend)
);

// File: tb/capture_timer_chan_test.sv
`timescale 1ns/1ps
module capture_timer_chan_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        freeze_i = 1'b0;
  logic        cap_a_i = 1'b0;
  logic        cap_b_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  capture_timer_chan uut (
    .clk_i(clk), .rst_ni(rst_ni), .freeze_i(freeze_i),
    .cap_a_i(cap_a_i), .cap_b_i(cap_b_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  localparam logic [2:0] CTRL = 0, PRESC = 1, COUNT = 2, CAPA = 3,
                         CAPB = 4, EN = 5, PEND = 6;

  // {P, enabled edges, expected count}
  localparam int VP[6] = '{0, 1, 2, 3, 7, 255};
  localparam int VK[6] = '{10, 10, 10, 17, 40, 600};
  localparam int VE[6] = '{10, 5, 3, 4, 5, 2};

  function automatic logic [15:0] cw(input logic [1:0] mode, input bit run,
      input bit lp, input logic [1:0] ea, input logic [1:0] eb,
      input bit ra, input bit rb);
    return {6'd0, rb, ra, eb, ea, lp, run, mode};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    #1;
    chk(req, {15'd0, irq_o}, {15'd0, exp});
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);
    // R1 reset state
    rd_chk("R1 ctrl", CTRL, 16'h0);
    rd_chk("R1 count", COUNT, 16'h0);
    rd_chk("R1 pend", PEND, 16'h0);
    irq_chk("R1 irq", 1'b0);

    // R2 prescaler vectors
    for (int i = 0; i < 6; i++) begin
      wr(PRESC, 16'(VP[i]));
      wr(COUNT, 16'h0);
      wr(CTRL, cw(2'b11, 1, 0, 0, 0, 0, 0));
      wait_n(VK[i] - 1);
      wr(CTRL, cw(2'b11, 0, 0, 0, 0, 0, 0));
      rd_chk("R2 prescale", COUNT, 16'(VE[i]));
    end

    // R2 wrong mode: no counting
    wr(PRESC, 16'h0);
    wr(COUNT, 16'h0);
    wr(CTRL, cw(2'b01, 1, 0, 0, 0, 0, 0));
    wait_n(10);
    rd_chk("R2 mode gate", COUNT, 16'h0);

    // R4/R5 capture latency on running counter
    wr(CTRL, cw(2'b11, 1, 0, 2'b01, 0, 0, 0));
    cap_a_i = 1'b1;
    wait_n(3);
    rd_chk("R4 capture timing", CAPA, 16'h0002);
    rd_chk("R5 pend A", PEND, 16'h0001);
    wr(CTRL, cw(2'b11, 0, 0, 2'b01, 0, 0, 0));
    wr(PEND, 16'h000F);
    rd_chk("R7 w1c", PEND, 16'h0);

    // R4 falling on B, rising ignored; A with none
    wr(CTRL, cw(2'b11, 0, 0, 2'b00, 2'b10, 0, 0));
    wr(COUNT, 16'h1234);
    cap_b_i = 1'b1;
    cap_a_i = 1'b0;
    wait_n(5);
    rd_chk("R4 rise ignored on fall sel", CAPB, 16'h0);
    rd_chk("R4 none sel", CAPA, 16'h0002);
    cap_b_i = 1'b0;
    wait_n(5);
    rd_chk("R5 cap B", CAPB, 16'h1234);
    rd_chk("R5 pend B", PEND, 16'h0002);
    wr(PEND, 16'h000F);

    // R4 both edges
    wr(CTRL, cw(2'b11, 0, 0, 2'b11, 0, 0, 0));
    wr(COUNT, 16'h0100);
    cap_a_i = 1'b1;
    wait_n(5);
    rd_chk("R4 both rise", CAPA, 16'h0100);
    wr(COUNT, 16'h0200);
    cap_a_i = 1'b0;
    wait_n(5);
    rd_chk("R4 both fall", CAPA, 16'h0200);

    // R6 restart
    wr(CTRL, cw(2'b11, 0, 0, 2'b01, 0, 1, 0));
    wr(COUNT, 16'h0055);
    cap_a_i = 1'b1;
    wait_n(5);
    rd_chk("R6 latched", CAPA, 16'h0055);
    rd_chk("R6 restart", COUNT, 16'h0);
    cap_a_i = 1'b0;
    wr(PEND, 16'h000F);

    // R3 overflow, R7 irq
    wr(CTRL, cw(2'b11, 0, 0, 0, 0, 0, 0));
    wr(COUNT, 16'hFFFF);
    wr(EN, 16'h0004);
    irq_chk("R7 irq idle", 1'b0);
    wr(CTRL, cw(2'b11, 1, 0, 0, 0, 0, 0));
    wr(CTRL, cw(2'b11, 0, 0, 0, 0, 0, 0));
    rd_chk("R3 wrap", COUNT, 16'h0);
    rd_chk("R3 pend C", PEND, 16'h0004);
    irq_chk("R7 irq set", 1'b1);
    wr(PEND, 16'h0004);
    rd_chk("R7 cleared", PEND, 16'h0);
    irq_chk("R7 irq cleared", 1'b0);

    // R8 set beats clear
    wr(EN, 16'h0001);
    wr(CTRL, cw(2'b11, 0, 0, 2'b01, 0, 0, 0));
    wait_n(4);
    cap_a_i = 1'b1;
    wait_n(2);
    wr(PEND, 16'h0001);
    rd_chk("R8 set wins", PEND, 16'h0001);
    irq_chk("R8 irq", 1'b1);
    wr(PEND, 16'h0001);
    cap_a_i = 1'b0;
    wait_n(4);
    rd_chk("R8 clear later", PEND, 16'h0);

    // R9 low power
    wr(COUNT, 16'h0077);
    cap_a_i = 1'b1;
    wait_n(4);
    cap_a_i = 1'b0;
    wr(COUNT, 16'h0088);
    wait_n(4);
    wr(CTRL, cw(2'b11, 1, 1, 2'b01, 0, 0, 0));
    wr(COUNT, 16'h9999);
    wait_n(20);
    rd_chk("R9 count hold", COUNT, 16'h0088);
    wr(CAPA, 16'hAAAA);
    rd_chk("R9 cap write ignored", CAPA, 16'h0077);
    wr(PEND, 16'h000F);
    rd_chk("R9 no clear", PEND, 16'h0001);
    irq_chk("R9 irq held", 1'b1);
    cap_a_i = 1'b1;
    wait_n(5);
    rd_chk("R9 no capture", CAPA, 16'h0077);
    rd_chk("R11 ctrl readback", CTRL, cw(2'b11, 1, 1, 2'b01, 0, 0, 0));
    wr(CTRL, cw(2'b11, 0, 0, 2'b01, 0, 0, 0));
    wr(PEND, 16'h000F);
    rd_chk("R9 clear after exit", PEND, 16'h0);
    cap_a_i = 1'b0;

    // R10 freeze
    wr(COUNT, 16'h0);
    freeze_i = 1'b1;
    wr(CTRL, cw(2'b11, 1, 0, 0, 2'b01, 0, 0));
    wait_n(10);
    rd_chk("R10 frozen count", COUNT, 16'h0);
    cap_b_i = 1'b1;
    wait_n(5);
    freeze_i = 1'b0;
    rd_chk("R10 no capture", CAPB, 16'h1234);
    rd_chk("R10 no pend", PEND, 16'h0);
    wait_n(4);
    freeze_i = 1'b1;
    rd_chk("R10 resumed", COUNT, 16'h0004);
    wait_n(3);
    rd_chk("R10 held again", COUNT, 16'h0004);
    freeze_i = 1'b0;
    wr(CTRL, cw(2'b11, 0, 0, 0, 2'b01, 0, 0));
    rd_chk("R10 resume from held", COUNT, 16'h0005);
    rd_chk("R10 cap after freeze", CAPB, 16'h1234);

    // R11
    rd_chk("R11 unmapped", 3'd7, 16'h0);
    rd_chk("R11 bit D clear", PEND, 16'h0);
    rd_chk("R11 presc readback", PRESC, 16'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule